// File: doc/BRIEF.md
# Exception Vector and Return Unit

This unit decides where the pipeline goes when an exception event is taken and when the return-from-exception instruction runs. Each cycle it can take one event. An event is a fault, a trap or an interrupt, named by a 4-bit code. It can also take one return request. The caller supplies the current PC and the firmware base address. Bit 0 of the current PC marks privileged (firmware) mode. One cycle later the unit presents a registered redirect: the new PC and the next PC. It also presents the updated exception address register and single-cycle requests to enter or leave the shadow register set.

The unit picks the vector offset for the code and adds it to the base. Every offset has bit 0 set, so the target runs in privileged mode. The restart address depends on the class of the event:

- Traps skip the instruction that caused them.
- Faults point back at that instruction.
- An interrupt that arrives while already in privileged mode keeps the address saved earlier.

A return issued outside privileged mode is illegal. The unit flags it and takes the unimplemented-opcode vector in its place. The exception address register can also be written through a control path. Such a write always clears bit 1.

Top module: `exc_vector_unit`

## Requirements
- R1: In the first cycle after `rst_n` is released, the outputs show a redirect to `RESET_BASE + 0x001` with next PC `RESET_BASE + 0x005`. In the same cycle `shadow_on` is 1, `exc_addr` is 0, and `shadow_off` and `ret_fault` are 0.
- R2: Each event code selects a vector offset:
  - 0 reset → 0x0001
  - 1 machine check → 0x0401
  - 2 arithmetic → 0x0501
  - 3 interrupt → 0x0101
  - 4 native data-TLB miss → 0x0201
  - 5 privileged data-TLB miss → 0x0281
  - 6 alignment → 0x0301
  - 7 data-TLB fault → 0x0381
  - 8 data access violation → 0x0381
  - 9 instruction-TLB miss → 0x0181
  - 10 instruction-TLB fault → 0x0181
  - 11 instruction access violation → 0x0081
  - 12 unimplemented opcode → 0x0481
  - 13 FP disabled → 0x0581
  - 14 firmware call → 0x2001
  - 15 integer overflow → 0x0501
- R3: An event sampled with `ev_valid` = 1 produces, on the next cycle, `redir_valid` = 1, `redir_pc` = `fw_base` + offset and `redir_npc` = `redir_pc` + 4.
- R4: A taken event loads `exc_addr` with `cur_pc`. For the trap codes 2, 14 and 15 it loads `cur_pc` + 4 instead.
- R5: An interrupt (code 3) taken while `cur_pc[0]` = 1 leaves `exc_addr` unchanged, but still redirects.
- R6: A taken event pulses `shadow_on` for one cycle when `cur_pc[0]` = 0. When `cur_pc[0]` = 1, `shadow_on` stays 0.
- R7: A return with `cur_pc[0]` = 1 redirects to the current `exc_addr`, with next PC `exc_addr` + 4. It pulses `shadow_off` when `exc_addr[0]` = 0.
- R8: A return with `cur_pc[0]` = 0 pulses `ret_fault` and is handled exactly as an unimplemented-opcode event (code 12) at `cur_pc`.
- R9: A control write with no event and no illegal return loads `exc_addr` with `ea_wr_data` and bit 1 cleared. It produces no redirect.
- R10: Priority works as follows:
  - An event wins over a return in the same cycle.
  - An event or an illegal return wins over a control write for `exc_addr`.
  - A cycle with no event and no return gives `redir_valid` = 0, with all pulses 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | 1 | An event is taken this cycle |
| ev_code | input | 4 | Event code (see R2) |
| cur_pc | input | PC_W | PC of the excepting instruction; bit 0 = privileged mode |
| fw_base | input | PC_W | Firmware base address |
| ret_req | input | 1 | Return-from-exception request |
| ea_wr_en | input | 1 | Control-path write of the exception address |
| ea_wr_data | input | PC_W | Write data for the exception address |
| redir_valid | output | 1 | Redirect present this cycle |
| redir_pc | output | PC_W | New PC |
| redir_npc | output | PC_W | Next PC (new PC + 4) |
| exc_addr | output | PC_W | Exception address register |
| shadow_on | output | 1 | Request to switch in the shadow registers |
| shadow_off | output | 1 | Request to switch out the shadow registers |
| ret_fault | output | 1 | Return attempted outside privileged mode |

## Verification
The hardest cases to reach are the ones where the result depends on state left behind by earlier cycles. One is a privileged interrupt, which must leave a saved address from a previous event untouched. Another is a legal return, whose shadow-exit decision depends on bit 0 of an address that was loaded earlier. The stimulus builds these with chained sequences: an event or control write plants a known address, then a privileged interrupt or return follows at once, and the saved address is checked again afterwards. Collisions between an event, a return and a control write in the same cycle are driven on purpose to pin down the priority order.

// File: rtl/exv_pkg.sv
// Package exv_pkg
// Shared event codes and the vector-offset and trap-class tables for the
// exception vector unit. Assumes a 4-bit event code in which all 16 values
// are defined.
package exv_pkg;
    localparam int CODE_W = 4;
    localparam int OFF_W  = 14;

    typedef enum logic [CODE_W-1:0] {
        EV_RESET  = 4'd0,  EV_MCHK   = 4'd1,  EV_ARITH  = 4'd2,  EV_INTR   = 4'd3,
        EV_NDTB   = 4'd4,  EV_PDTB   = 4'd5,  EV_ALIGN  = 4'd6,  EV_DFAULT = 4'd7,
        EV_DACV   = 4'd8,  EV_IMISS  = 4'd9,  EV_IFAULT = 4'd10, EV_IACV   = 4'd11,
        EV_UNIMPL = 4'd12, EV_FPDIS  = 4'd13, EV_FWCALL = 4'd14, EV_IOVF   = 4'd15
    } ev_code_e;

    // Vector offset for an event; bit 0 always marks privileged mode
    function automatic logic [OFF_W-1:0] vec_offset(ev_code_e c);
        case (c)
            EV_RESET:             return 14'h0001;
            EV_MCHK:              return 14'h0401;
            EV_ARITH, EV_IOVF:    return 14'h0501;
            EV_INTR:              return 14'h0101;
            EV_NDTB:              return 14'h0201;
            EV_PDTB:              return 14'h0281;
            EV_ALIGN:             return 14'h0301;
            EV_DFAULT, EV_DACV:   return 14'h0381;
            EV_IMISS, EV_IFAULT:  return 14'h0181;
            EV_IACV:              return 14'h0081;
            EV_UNIMPL:            return 14'h0481;
            EV_FPDIS:             return 14'h0581;
            default:              return 14'h2001;
        endcase
    endfunction

    // Trap-class events restart after the instruction that raised them
    function automatic logic is_trap(ev_code_e c);
        return (c == EV_ARITH) || (c == EV_IOVF) || (c == EV_FWCALL);
    endfunction
endpackage

// File: rtl/exv_vector_table.sv
// Module exv_vector_table
// Turns an event code into its target address (base + offset) and a
// trap-class flag. Purely combinational. Assumes PC_W is wider than the
// offset field.
module exv_vector_table
    import exv_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic [CODE_W-1:0] code,
    input  logic [PC_W-1:0]   base,
    output logic [PC_W-1:0]   target,
    output logic              trap
);
    localparam int PAD_W = PC_W - OFF_W;

    logic [OFF_W-1:0] off;

    // Look up the offset and class, then add the offset to the base
    always_comb begin
        off    = vec_offset(ev_code_e'(code));
        trap   = is_trap(ev_code_e'(code));
        target = base + {{PAD_W{1'b0}}, off};
    end
endmodule

// File: rtl/exv_mode_ctl.sv
// Module exv_mode_ctl
// Sorts the requests of one cycle into actions: take an event, return
// legally or return illegally. It also picks the shadow enter/exit requests
// and the effective event code. Assumes bit 0 of the PC flags privileged mode.
module exv_mode_ctl
    import exv_pkg::*;
(
    input  logic              ev_valid,
    input  logic [CODE_W-1:0] ev_code,
    input  logic              ret_req,
    input  logic              priv,
    input  logic              saved_priv,
    output logic              take,
    output logic              ret_ok,
    output logic              ret_bad,
    output logic [CODE_W-1:0] eff_code,
    output logic              enter_shadow,
    output logic              leave_shadow
);
    // Event beats return; an illegal return becomes an unimplemented-opcode event
    always_comb begin
        ret_ok       = ret_req && !ev_valid && priv;
        ret_bad      = ret_req && !ev_valid && !priv;
        take         = ev_valid || ret_bad;
        eff_code     = ev_valid ? ev_code : EV_UNIMPL;
        enter_shadow = take && !priv;
        leave_shadow = ret_ok && !saved_priv;
    end

    // R10
    exclusive_actions_chk: assert final ($countones({take, ret_ok}) <= 1);
endmodule

// File: rtl/exv_restart.sv
// Module exv_restart
// Next value of the exception address register. A taken event saves the PC
// (plus one instruction for traps), except for an interrupt in privileged
// mode. Otherwise a control write loads data with bit 1 cleared.
module exv_restart
    import exv_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int STEP  = 4
) (
    input  logic              take,
    input  logic [CODE_W-1:0] code,
    input  logic              trap,
    input  logic              priv,
    input  logic [PC_W-1:0]   cur_pc,
    input  logic              wr_en,
    input  logic [PC_W-1:0]   wr_data,
    input  logic [PC_W-1:0]   exc_q,
    output logic [PC_W-1:0]   exc_d
);
    localparam logic [PC_W-1:0] STEP_V   = PC_W'(STEP);
    localparam logic [PC_W-1:0] BIT1_CLR = ~(PC_W'(2));

    logic keep;

    // Choose the restart address by event class, then control write, then hold
    always_comb begin
        keep = (ev_code_e'(code) == EV_INTR) && priv;
        if (take) begin
            if (keep)      exc_d = exc_q;
            else if (trap) exc_d = cur_pc + STEP_V;
            else           exc_d = cur_pc;
        end else if (wr_en) begin
            exc_d = wr_data & BIT1_CLR;
        end else begin
            exc_d = exc_q;
        end
    end
endmodule

// File: rtl/exc_vector_unit.sv
// Module exc_vector_unit
// Top of the exception vector and return unit. Registers the redirect,
// the exception address and the single-cycle mode requests one cycle after
// the inputs are sampled. Assumes a synchronous active-low reset and that
// the reset vector base is fixed by a parameter.
module exc_vector_unit
    import exv_pkg::*;
#(
    parameter int              PC_W       = 32,
    parameter int              STEP       = 4,
    parameter logic [PC_W-1:0] RESET_BASE = 32'h0000_8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [CODE_W-1:0] ev_code,
    input  logic [PC_W-1:0]   cur_pc,
    input  logic [PC_W-1:0]   fw_base,
    input  logic              ret_req,
    input  logic              ea_wr_en,
    input  logic [PC_W-1:0]   ea_wr_data,
    output logic              redir_valid,
    output logic [PC_W-1:0]   redir_pc,
    output logic [PC_W-1:0]   redir_npc,
    output logic [PC_W-1:0]   exc_addr,
    output logic              shadow_on,
    output logic              shadow_off,
    output logic              ret_fault
);
    localparam logic [PC_W-1:0] STEP_V  = PC_W'(STEP);
    localparam logic [PC_W-1:0] RST_VEC = RESET_BASE + PC_W'(vec_offset(EV_RESET));

    logic              take, ret_ok, ret_bad, enter_sh, leave_sh, trap;
    logic [CODE_W-1:0] eff_code;
    logic [PC_W-1:0]   vec_pc, exc_d, tgt_pc;

    exv_mode_ctl u_mode (
        .ev_valid     (ev_valid),
        .ev_code      (ev_code),
        .ret_req      (ret_req),
        .priv         (cur_pc[0]),
        .saved_priv   (exc_addr[0]),
        .take         (take),
        .ret_ok       (ret_ok),
        .ret_bad      (ret_bad),
        .eff_code     (eff_code),
        .enter_shadow (enter_sh),
        .leave_shadow (leave_sh)
    );

    exv_vector_table #(.PC_W(PC_W)) u_vec (
        .code   (eff_code),
        .base   (fw_base),
        .target (vec_pc),
        .trap   (trap)
    );

    exv_restart #(.PC_W(PC_W), .STEP(STEP)) u_rst (
        .take    (take),
        .code    (eff_code),
        .trap    (trap),
        .priv    (cur_pc[0]),
        .cur_pc  (cur_pc),
        .wr_en   (ea_wr_en),
        .wr_data (ea_wr_data),
        .exc_q   (exc_addr),
        .exc_d   (exc_d)
    );

    // Redirect target: the vector for an event, the saved address for a return
    always_comb tgt_pc = take ? vec_pc : exc_addr;

    // Register the outputs; reset leaves the reset vector in place
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redir_valid <= 1'b1;
            redir_pc    <= RST_VEC;
            redir_npc   <= RST_VEC + STEP_V;
            exc_addr    <= '0;
            shadow_on   <= 1'b1;
            shadow_off  <= 1'b0;
            ret_fault   <= 1'b0;
        end else begin
            redir_valid <= take || ret_ok;
            if (take || ret_ok) begin
                redir_pc  <= tgt_pc;
                redir_npc <= tgt_pc + STEP_V;
            end
            exc_addr    <= exc_d;
            shadow_on   <= enter_sh;
            shadow_off  <= leave_sh;
            ret_fault   <= ret_bad;
        end
    end

    // R5
    priv_intr_keeps_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_code == EV_INTR && cur_pc[0]) |=> $stable(exc_addr));

    // R6
    shadow_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !cur_pc[0]) |=> (shadow_on && !shadow_off));

    // R6
    shadow_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && cur_pc[0]) |=> !shadow_on);

    // R8
    illegal_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && !ev_valid && !cur_pc[0]) |=> (ret_fault && redir_valid && shadow_on));

    // R9
    ctl_write_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ea_wr_en && !ev_valid && !ret_req) |=> (!redir_valid && !exc_addr[1]));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ev_valid && !ret_req) |=> (!redir_valid && !shadow_on && !shadow_off && !ret_fault));

    // R3
    redirect_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !fw_base[0]) |=> (redir_valid && redir_pc[0]));
endmodule

// File: tb/exc_vector_unit_tb.sv
`timescale 1ns/1ps
module exc_vector_unit_tb;
    localparam logic [31:0] RBASE = 32'h0000_8000;
    localparam logic [31:0] FBASE = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev_valid = 1'b0, ret_req = 1'b0, ea_wr_en = 1'b0;
    logic [3:0]  ev_code = '0;
    logic [31:0] cur_pc = '0, ea_wr_data = '0;
    logic        redir_valid, shadow_on, shadow_off, ret_fault;
    logic [31:0] redir_pc, redir_npc, exc_addr;

    always #2 clk = ~clk;

    exc_vector_unit u_dut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_code(ev_code),
        .cur_pc(cur_pc), .fw_base(FBASE), .ret_req(ret_req),
        .ea_wr_en(ea_wr_en), .ea_wr_data(ea_wr_data),
        .redir_valid(redir_valid), .redir_pc(redir_pc), .redir_npc(redir_npc),
        .exc_addr(exc_addr), .shadow_on(shadow_on), .shadow_off(shadow_off),
        .ret_fault(ret_fault)
    );

    typedef struct {
        logic        v;
        logic [31:0] pc, npc, exc;
        logic        son, soff, rf;
        string       tag;
    } exp_t;

    exp_t        q[$];
    int          n_chk = 0, n_fail = 0;
    logic [31:0] m_exc = '0;
    bit          done = 0;

    function automatic logic [31:0] offs(logic [3:0] c);
        case (c)
            4'd0: return 32'h0001;  4'd1: return 32'h0401;  4'd2: return 32'h0501;
            4'd3: return 32'h0101;  4'd4: return 32'h0201;  4'd5: return 32'h0281;
            4'd6: return 32'h0301;  4'd7: return 32'h0381;  4'd8: return 32'h0381;
            4'd9: return 32'h0181;  4'd10: return 32'h0181; 4'd11: return 32'h0081;
            4'd12: return 32'h0481; 4'd13: return 32'h0581; 4'd14: return 32'h2001;
            default: return 32'h0501;
        endcase
    endfunction

    // Driver: apply one cycle of stimulus and queue the expected result
    task automatic step(bit ev, logic [3:0] code, logic [31:0] pc, bit ret,
                        bit we, logic [31:0] wd, string tag);
        exp_t e;
        bit priv = pc[0];
        bit bad  = ret && !ev && !priv;
        bit ok   = ret && !ev && priv;
        logic [3:0] c = ev ? code : 4'd12;
        @(negedge clk);
        ev_valid = ev; ev_code = code; cur_pc = pc; ret_req = ret;
        ea_wr_en = we; ea_wr_data = wd;
        e.v = 0; e.pc = '0; e.npc = '0; e.son = 0; e.soff = 0; e.rf = 0; e.tag = tag;
        if (ev || bad) begin
            e.v = 1; e.pc = FBASE + offs(c); e.npc = e.pc + 4;
            e.son = !priv; e.rf = bad;
            if (!(c == 4'd3 && priv))
                m_exc = (c == 4'd2 || c == 4'd14 || c == 4'd15) ? pc + 4 : pc;
        end else if (ok) begin
            e.v = 1; e.pc = m_exc; e.npc = m_exc + 4; e.soff = !m_exc[0];
            if (we) m_exc = wd & ~32'h2;
        end else if (we) begin
            m_exc = wd & ~32'h2;
        end
        e.exc = m_exc;
        q.push_back(e);
    endtask

    // Monitor: compare registered outputs shortly after each rising edge
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (redir_valid !== e.v || exc_addr !== e.exc || shadow_on !== e.son ||
                shadow_off !== e.soff || ret_fault !== e.rf ||
                (e.v && (redir_pc !== e.pc || redir_npc !== e.npc))) begin
                n_fail++;
                $display("FAIL %s: got v=%0b pc=%h npc=%h exc=%h on=%0b off=%0b rf=%0b exp v=%0b pc=%h npc=%h exc=%h on=%0b off=%0b rf=%0b",
                         e.tag, redir_valid, redir_pc, redir_npc, exc_addr, shadow_on,
                         shadow_off, ret_fault, e.v, e.pc, e.npc, e.exc, e.son, e.soff, e.rf);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout exp completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset vector visible in the first cycle after release
        n_chk++;
        if (redir_valid !== 1'b1 || redir_pc !== RBASE + 32'h1 || redir_npc !== RBASE + 32'h5 ||
            shadow_on !== 1'b1 || exc_addr !== 32'h0 || shadow_off !== 1'b0 || ret_fault !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: got v=%0b pc=%h npc=%h on=%0b exc=%h exp v=1 pc=%h npc=%h on=1 exc=0",
                     redir_valid, redir_pc, redir_npc, shadow_on, exc_addr, RBASE + 32'h1, RBASE + 32'h5);
        end
        step(0, 0, 32'h0, 0, 0, 0, "R10 idle");
        step(1, 4'd12, 32'h1000, 0, 0, 0, "R3 R4 R6 unimpl from user");
        step(1, 4'd14, 32'h2000, 0, 0, 0, "R4 fwcall skip");
        step(1, 4'd2, 32'h3001, 0, 0, 0, "R4 R6 arith privileged");
        step(1, 4'd15, 32'h3100, 0, 0, 0, "R2 R4 overflow");
        step(1, 4'd3, 32'h4001, 0, 0, 0, "R5 priv interrupt keeps addr");
        step(0, 0, 32'h4001, 0, 0, 0, "R5 addr still held");
        step(1, 4'd3, 32'h4000, 0, 0, 0, "R4 R6 user interrupt saves");
        for (int c = 0; c < 16; c++)
            step(1, 4'(c), 32'h7000 + 32'(c) * 16, 0, 0, 0, "R2 vector table");
        step(0, 0, 32'h8000, 0, 1, 32'hFFFF_FFFF, "R9 write clears bit1");
        step(0, 0, 32'h8001, 0, 1, 32'h0000_5000, "R9 write even addr");
        step(0, 0, 32'h8001, 1, 0, 0, "R7 return to user");
        step(0, 0, 32'h8001, 0, 1, 32'h0000_5003, "R9 write odd addr");
        step(0, 0, 32'h8001, 1, 0, 0, "R7 return stays privileged");
        step(0, 0, 32'h6000, 1, 0, 0, "R8 illegal return");
        step(1, 4'd6, 32'h9001, 1, 0, 0, "R10 event beats return");
        step(1, 4'd1, 32'hA000, 0, 1, 32'h1234_5678, "R10 event beats write");
        step(0, 0, 32'hB000, 1, 1, 32'h1111_1110, "R10 illegal return beats write");
        step(0, 0, 32'hB001, 1, 1, 32'h2222_2222, "R7 R9 return with write");
        step(0, 0, 32'h0, 0, 0, 0, "R10 idle after");
        @(negedge clk);
        ev_valid = 0; ret_req = 0; ea_wr_en = 0;
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule